// File: doc/BRIEF.md
# Exception Control Unit

This block holds the processor control registers that an in-order RISC core uses to take exceptions and to return from them. It keeps a status register, a cause register, an exception PC and a bad virtual address register. A trap can come from three places: a synchronous request from the core, an unmasked pending interrupt, or a register move attempted outside kernel mode. When one is taken, the block saves the restart address and records the reason. It then pushes a three-level stack of mode and interrupt-enable pairs and, in the next cycle, sends the core to a fixed vector.

A return pulse pops the stack. Move-to and move-from ports give the core access to the registers while it runs in kernel mode. The register select codes used on these ports are 8 for the bad address, 12 for status, 13 for cause and 14 for the exception PC.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset every register reads zero. The unit is in kernel mode with interrupts off, `user_mode_o` is 0 and `redirect_o` is 0.
- R2: When a trap is taken, status[5:0] becomes {old status[3:0], 2'b00}. Status holds three pairs: bit 1 is the mode bit (0 kernel, 1 user) and bit 0 is the interrupt enable (1 on), with two older pairs above them.
- R3: When a trap is taken, the exception PC gets `exc_pc_i`, or `exc_pc_i` - 4 when `exc_bd_i` is 1. Cause bit 31 records `exc_bd_i`.
- R4: The trap code goes into cause[6:2]. A synchronous request stores `exc_code_i`, an interrupt stores 0 and a privilege fault stores 11.
- R5: The cycle after a trap is taken, `redirect_o` is 1 for exactly one cycle with `redirect_pc_o` = 0x80000080. At all other times `redirect_pc_o` is 0.
- R6: When `rfe_i` is high and no trap is taken, status[5:0] becomes {old[5:4], old[5:2]}. In that cycle the return has priority over a status move-to.
- R7: Cause[15:8] shows the live pending set. Bits 15:10 are `irq_i[5:0]` and bits 9:8 are the software bits. Only those two bits are written by a move-to of cause; every other cause bit ignores it.
- R8: An interrupt is taken only when status bit 0 is 1 and some pending bit of cause[15:8] has its mask bit set in status[15:8].
- R9: A synchronous request wins over a privilege fault and over an interrupt in the same cycle.
- R10: The bad address register loads `exc_badaddr_i` only for a synchronous request with code 4 or 5. Otherwise it holds its value.
- R11: In user mode a move-to or move-from writes nothing, and a move-from returns 0. Either one raises a trap with code 11 and cause[29:28] set to the coprocessor number (0).
- R12: A move-to of status in kernel mode writes bits 15:8 and 5:0. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Synchronous trap request from the core |
| exc_code_i | input | 5 | Code for the synchronous request |
| exc_pc_i | input | 32 | PC of the faulting or interrupted instruction |
| exc_bd_i | input | 1 | Instruction sits in a branch delay slot |
| exc_badaddr_i | input | 32 | Faulting address for address errors |
| irq_i | input | 6 | External interrupt lines |
| rfe_i | input | 1 | Return-from-exception pulse |
| mt_en_i | input | 1 | Move-to strobe |
| mf_en_i | input | 1 | Move-from strobe |
| reg_sel_i | input | 5 | Register select for moves |
| mt_data_i | input | 32 | Move-to data |
| mf_data_o | output | 32 | Move-from data (combinational) |
| redirect_o | output | 1 | One-cycle PC redirect to the vector |
| redirect_pc_o | output | 32 | Redirect target |
| user_mode_o | output | 1 | Current mode bit |

## Verification
The assertions assume that reset is released only between clock edges. They also assume that each input is stable for the whole cycle and that `exc_code_i` is meaningful whenever `exc_req_i` is high.

The bench changes every input only on the falling edge, so these assumptions always hold. Random moves are allowed to reach any mode-stack pattern, including user mode, because the privilege check and the interrupt gating are themselves part of the checked behaviour.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned SEL_W  = 5;

  localparam logic [CODE_W-1:0] CODE_IRQ  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_ADRL = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADRS = 5'd5;
  localparam logic [CODE_W-1:0] CODE_CPU  = 5'd11;

  localparam logic [SEL_W-1:0] SEL_BADVA  = 5'd8;
  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  localparam int unsigned POS_PEND = 8;
  localparam int unsigned POS_CODE = 2;
  localparam int unsigned POS_CE   = 28;
  localparam int unsigned POS_BD   = 31;

  typedef struct packed {
    logic              take;
    logic              badva_wr;
    logic              set_ce;
    logic [CODE_W-1:0] code;
  } trap_dec_t;
endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned MASK_W = 8,
  localparam int unsigned KS_W  = 2 * LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              wr_en,
  input  logic [KS_W-1:0]   wr_ks,
  input  logic [MASK_W-1:0] wr_mask,
  output logic [KS_W-1:0]   ks_q,
  output logic [MASK_W-1:0] mask_q
);
  logic [KS_W-1:0]   ks_d;
  logic [MASK_W-1:0] mask_d;
  logic              upd;

  always_comb begin
    ks_d   = ks_q;
    mask_d = mask_q;
    if (push) begin
      ks_d = {ks_q[KS_W-3:0], 2'b00};
    end else if (pop) begin
      ks_d = {ks_q[KS_W-1 -: 2], ks_q[KS_W-1:2]};
    end else if (wr_en) begin
      ks_d   = wr_ks;
      mask_d = wr_mask;
    end
  end

  assign upd = push | pop | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_q   <= '0;
      mask_q <= '0;
    end else if (upd) begin
      ks_q   <= ks_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_pkg::*; #(
  parameter int unsigned PEND_W = 8
) (
  input  logic              sync_req,
  input  logic [CODE_W-1:0] sync_code,
  input  logic              priv_fault,
  input  logic              ie_cur,
  input  logic [PEND_W-1:0] pend,
  input  logic [PEND_W-1:0] mask,
  output trap_dec_t         dec
);
  logic irq_hit;

  assign irq_hit = ie_cur & (|(pend & mask));

  always_comb begin
    dec = '0;
    if (sync_req) begin
      dec.take     = 1'b1;
      dec.code     = sync_code;
      dec.badva_wr = (sync_code == CODE_ADRL) || (sync_code == CODE_ADRS);
    end else if (priv_fault) begin
      dec.take   = 1'b1;
      dec.code   = CODE_CPU;
      dec.set_ce = 1'b1;
    end else if (irq_hit) begin
      dec.take = 1'b1;
      dec.code = CODE_IRQ;
    end
  end
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg import exc_pkg::*; #(
  parameter int unsigned N_SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code_in,
  input  logic              bd_in,
  input  logic [1:0]        ce_in,
  input  logic              sw_wr,
  input  logic [N_SW-1:0]   sw_in,
  output logic [CODE_W-1:0] code_q,
  output logic              bd_q,
  output logic [1:0]        ce_q,
  output logic [N_SW-1:0]   sw_q
);
  logic [CODE_W-1:0] code_d;
  logic              bd_d;
  logic [1:0]        ce_d;
  logic [N_SW-1:0]   sw_d;

  always_comb begin
    code_d = code_q;
    bd_d   = bd_q;
    ce_d   = ce_q;
    sw_d   = sw_q;
    if (take) begin
      code_d = code_in;
      bd_d   = bd_in;
      ce_d   = ce_in;
    end
    if (sw_wr) sw_d = sw_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
      ce_q   <= '0;
    end else if (take) begin
      code_q <= code_d;
      bd_q   <= bd_d;
      ce_q   <= ce_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_wr) sw_q <= sw_d;
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit import exc_pkg::*; #(
  parameter int unsigned N_EXT_IRQ = 6,
  parameter int unsigned N_SW_IRQ  = 2,
  parameter logic [31:0] VECTOR    = 32'h8000_0080,
  parameter logic [1:0]  COP_NUM   = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   exc_pc_i,
  input  logic              exc_bd_i,
  input  logic [XLEN-1:0]   exc_badaddr_i,
  input  logic [N_EXT_IRQ-1:0] irq_i,
  input  logic              rfe_i,
  input  logic              mt_en_i,
  input  logic              mf_en_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [XLEN-1:0]   mt_data_i,
  output logic [XLEN-1:0]   mf_data_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              user_mode_o
);
  localparam int unsigned PEND_W = N_EXT_IRQ + N_SW_IRQ;
  localparam int unsigned LEVELS = 3;
  localparam int unsigned KS_W   = 2 * LEVELS;

  logic [KS_W-1:0]     ks_q;
  logic [PEND_W-1:0]   mask_q;
  logic [CODE_W-1:0]   code_q;
  logic                bd_q;
  logic [1:0]          ce_q;
  logic [N_SW_IRQ-1:0] sw_q;
  logic [XLEN-1:0]     epc_q, epc_d;
  logic [XLEN-1:0]     badva_q;
  logic                redirect_q;
  logic [PEND_W-1:0]   pend;
  logic                kernel, priv_fault, mt_ok;
  logic                st_wr, sw_wr;
  trap_dec_t           dec;
  logic                unused_bits;

  assign kernel      = ~ks_q[1];
  assign priv_fault  = (mt_en_i | mf_en_i) & ~kernel;
  assign pend        = {irq_i, sw_q};
  assign mt_ok       = mt_en_i & kernel & ~dec.take;
  assign st_wr       = mt_ok & (reg_sel_i == SEL_STATUS);
  assign sw_wr       = mt_ok & (reg_sel_i == SEL_CAUSE);
  assign unused_bits = ^mt_data_i;

  exc_arbiter #(.PEND_W(PEND_W)) u_arb (
    .sync_req  (exc_req_i),
    .sync_code (exc_code_i),
    .priv_fault(priv_fault),
    .ie_cur    (ks_q[0]),
    .pend      (pend),
    .mask      (mask_q),
    .dec       (dec)
  );

  exc_mode_stack #(.LEVELS(LEVELS), .MASK_W(PEND_W)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (dec.take),
    .pop    (rfe_i),
    .wr_en  (st_wr),
    .wr_ks  (mt_data_i[KS_W-1:0]),
    .wr_mask(mt_data_i[POS_PEND +: PEND_W]),
    .ks_q   (ks_q),
    .mask_q (mask_q)
  );

  exc_cause_reg #(.N_SW(N_SW_IRQ)) u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (dec.take),
    .code_in(dec.code),
    .bd_in  (exc_bd_i),
    .ce_in  (dec.set_ce ? COP_NUM : 2'b00),
    .sw_wr  (sw_wr),
    .sw_in  (mt_data_i[POS_PEND +: N_SW_IRQ]),
    .code_q (code_q),
    .bd_q   (bd_q),
    .ce_q   (ce_q),
    .sw_q   (sw_q)
  );

  assign epc_d = exc_bd_i ? (exc_pc_i - 32'd4) : exc_pc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        epc_q <= '0;
    else if (dec.take) epc_q <= epc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            badva_q <= '0;
    else if (dec.badva_wr) badva_q <= exc_badaddr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect_q <= 1'b0;
    else        redirect_q <= dec.take;
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = redirect_q ? VECTOR : '0;
  assign user_mode_o   = ks_q[1];

  always_comb begin
    mf_data_o = '0;
    if (mf_en_i && kernel) begin
      unique case (reg_sel_i)
        SEL_STATUS: begin
          mf_data_o[KS_W-1:0]            = ks_q;
          mf_data_o[POS_PEND +: PEND_W]  = mask_q;
        end
        SEL_CAUSE: begin
          mf_data_o[POS_BD]              = bd_q;
          mf_data_o[POS_CE +: 2]         = ce_q;
          mf_data_o[POS_PEND +: PEND_W]  = pend;
          mf_data_o[POS_CODE +: CODE_W]  = code_q;
        end
        SEL_EPC:   mf_data_o = epc_q;
        SEL_BADVA: mf_data_o = badva_q;
        default:   mf_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_ctrl_checks.sv
module exc_ctrl_checks import exc_pkg::*; #(
  parameter logic [31:0] VECTOR = 32'h8000_0080
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_req_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              rfe_i,
  input logic              mt_en_i,
  input logic              mf_en_i,
  input logic              take,
  input logic [5:0]        ks_q,
  input logic [CODE_W-1:0] code_q,
  input logic [31:0]       badva_q,
  input logic              redirect_o,
  input logic [31:0]       redirect_pc_o
);
  a_r2_push: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |=> ks_q == {$past(ks_q[3:0]), 2'b00});

  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |=> redirect_o && redirect_pc_o == VECTOR);

  a_r6_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !take) |=> ks_q == {$past(ks_q[5:4]), $past(ks_q[5:2])});

  a_r9_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |=> code_q == $past(exc_code_i));

  a_r10_badva_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req_i && (exc_code_i == CODE_ADRL || exc_code_i == CODE_ADRS)) |=> $stable(badva_q));

  a_r11_user_trap: assert property (@(posedge clk) disable iff (!rst_n)
    ((mt_en_i || mf_en_i) && ks_q[1] && !exc_req_i) |=> code_q == CODE_CPU && redirect_o);
endmodule

bind exc_ctrl_unit exc_ctrl_checks #(.VECTOR(VECTOR)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_req_i    (exc_req_i),
  .exc_code_i   (exc_code_i),
  .rfe_i        (rfe_i),
  .mt_en_i      (mt_en_i),
  .mf_en_i      (mf_en_i),
  .take         (dec.take),
  .ks_q         (ks_q),
  .code_q       (code_q),
  .badva_q      (badva_q),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o)
);

// File: tb/exc_ctrl_unit_test.sv
`timescale 1ns/1ps
module exc_ctrl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, exc_bd, rfe, mt_en, mf_en;
  logic [4:0]  exc_code, sel;
  logic [31:0] exc_pc, exc_badaddr, mt_data;
  logic [5:0]  irq;
  logic [31:0] mf_data, redirect_pc;
  logic        redirect, user_mode;

  logic [5:0]  m_ks;
  logic [7:0]  m_im;
  logic [1:0]  m_sw;
  logic [4:0]  m_code;
  logic        m_bd;
  logic [1:0]  m_ce;
  logic [31:0] m_epc, m_badva;
  logic [31:0] last_read;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_code_i(exc_code),
    .exc_pc_i(exc_pc), .exc_bd_i(exc_bd), .exc_badaddr_i(exc_badaddr),
    .irq_i(irq), .rfe_i(rfe), .mt_en_i(mt_en), .mf_en_i(mf_en),
    .reg_sel_i(sel), .mt_data_i(mt_data), .mf_data_o(mf_data),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .user_mode_o(user_mode)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read();
    if (!mf_en || m_ks[1]) return 32'h0;
    case (sel)
      5'd12:   return {16'h0, m_im, 2'b00, m_ks};
      5'd13:   return {m_bd, 1'b0, m_ce, 12'h0, irq, m_sw, 1'b0, m_code, 2'b00};
      5'd14:   return m_epc;
      5'd8:    return m_badva;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag();
    if (mf_en && m_ks[1]) return "R11";
    case (sel)
      5'd12:   return "R12";
      5'd13:   return "R7";
      5'd14:   return "R3";
      5'd8:    return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic idle();
    exc_req = 0; exc_code = 0; exc_pc = 0; exc_bd = 0; exc_badaddr = 0;
    irq = 0; rfe = 0; mt_en = 0; mf_en = 0; sel = 0; mt_data = 0;
  endtask

  // one clock: check the read port, advance the model, check the registered outputs
  task automatic cyc();
    logic [7:0] ip;
    logic priv, hit, take;
    #1;
    last_read = mf_data;
    check(read_tag(), mf_data, exp_read());
    ip   = {irq, m_sw};
    priv = (mt_en | mf_en) & m_ks[1];
    hit  = m_ks[0] & (|(ip & m_im));
    take = exc_req | priv | hit;
    if (take) begin
      m_code = exc_req ? exc_code : (priv ? 5'd11 : 5'd0);
      m_bd   = exc_bd;
      m_ce   = 2'd0;
      m_epc  = exc_bd ? exc_pc - 32'd4 : exc_pc;
      if (exc_req && (exc_code == 5'd4 || exc_code == 5'd5)) m_badva = exc_badaddr;
      m_ks   = {m_ks[3:0], 2'b00};
    end else begin
      if (rfe) m_ks = {m_ks[5:4], m_ks[5:2]};
      else if (mt_en && sel == 5'd12 && !m_ks[1]) begin
        m_ks = mt_data[5:0];
        m_im = mt_data[15:8];
      end
      if (mt_en && sel == 5'd13 && !m_ks[1]) m_sw = mt_data[9:8];
    end
    @(posedge clk);
    #1;
    check("R5", {31'h0, redirect}, {31'h0, take});
    check("R5", redirect_pc, take ? 32'h8000_0080 : 32'h0);
    check("R6", {31'h0, user_mode}, {31'h0, m_ks[1]});
    @(negedge clk);
  endtask

  task automatic rd(logic [4:0] s);
    idle(); mf_en = 1; sel = s; cyc();
  endtask

  task automatic wr(logic [4:0] s, logic [31:0] d);
    idle(); mt_en = 1; sel = s; mt_data = d; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0;
    m_ks = 0; m_im = 0; m_sw = 0; m_code = 0; m_bd = 0; m_ce = 0; m_epc = 0; m_badva = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset values
    check("R1", {31'h0, redirect}, 32'h0);
    check("R1", {31'h0, user_mode}, 32'h0);
    rd(5'd12); check("R1", last_read, 32'h0);
    rd(5'd13); check("R1", last_read, 32'h0);
    rd(5'd14); check("R1", last_read, 32'h0);
    rd(5'd8);  check("R1", last_read, 32'h0);

    // R12: only bits 15:8 and 5:0 of status take a write
    wr(5'd12, 32'hABCD_00F4);
    rd(5'd12); check("R12", last_read, 32'h0000_0034);

    // R6: return pops the stack 110100 -> 111101
    idle(); rfe = 1; cyc();
    rd(5'd12); check("R6", last_read, 32'h0000_003D);

    // R8: masked line ignored, unmasked line taken with code 0 (R4)
    wr(5'd12, 32'h0000_0401);
    idle(); irq = 6'b000010; cyc();
    check("R8", {31'h0, redirect}, 32'h0);
    idle(); irq = 6'b000001; exc_pc = 32'h0000_1000; cyc();
    check("R8", {31'h0, redirect}, 32'h1);
    rd(5'd13); check("R4", last_read, 32'h0000_0000);
    rd(5'd12); check("R2", last_read, 32'h0000_0404);
    rd(5'd14); check("R3", last_read, 32'h0000_1000);

    // R3: delay-slot fault, syscall code 8
    idle(); exc_req = 1; exc_code = 5'd8; exc_pc = 32'h0000_2000; exc_bd = 1; cyc();
    rd(5'd14); check("R3", last_read, 32'h0000_1FFC);
    rd(5'd13); check("R3", last_read, 32'h8000_0020);

    // R9: synchronous request beats a live interrupt; R10 address error loads badva
    wr(5'd12, 32'h0000_FF01);
    idle(); irq = 6'b000001; exc_req = 1; exc_code = 5'd5; exc_badaddr = 32'hDEAD_BEE0; cyc();
    rd(5'd13); check("R9", last_read & 32'h7C, 32'h14);
    rd(5'd8);  check("R10", last_read, 32'hDEAD_BEE0);
    idle(); exc_req = 1; exc_code = 5'd8; exc_badaddr = 32'h1234_5678; cyc();
    rd(5'd8);  check("R10", last_read, 32'hDEAD_BEE0);

    // R11: user-mode move is blocked and traps with code 11
    wr(5'd12, 32'h0000_0002);
    check("R11", {31'h0, user_mode}, 32'h1);
    wr(5'd12, 32'h0000_0000);
    rd(5'd12); check("R11", last_read, 32'h0000_0008);
    rd(5'd13); check("R11", last_read, 32'h0000_002C);
    wr(5'd12, 32'h0000_0002);
    rd(5'd14); check("R11", last_read, 32'h0);

    // R7: move-to cause sets only the software pending bits
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13); check("R7", last_read, 32'h0000_032C);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      idle();
      exc_req     = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 3))
        0: exc_code = 5'd4;
        1: exc_code = 5'd5;
        2: exc_code = 5'd8;
        default: exc_code = 5'd10;
      endcase
      exc_pc      = $urandom & 32'hFFFF_FFFC;
      exc_bd      = $urandom_range(0, 1);
      exc_badaddr = $urandom;
      irq         = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
      rfe         = ($urandom_range(0, 9) == 0);
      mt_en       = ($urandom_range(0, 6) == 0);
      mf_en       = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 4))
        0: sel = 5'd12;
        1: sel = 5'd13;
        2: sel = 5'd14;
        3: sel = 5'd8;
        default: sel = 5'($urandom);
      endcase
      mt_data     = $urandom;
      cyc();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule